// File: doc/BRIEF.md
# Receive Buffer Rate-Control Monitor

This block watches the occupancy of a receive sample buffer. Arriving packets fill the buffer. A fixed-frequency local sample clock drains it, and that clock is never steered to follow the sender. The two clocks are nearly matched, so the level drifts slowly. Instead of recovering the sender's clock, the block closes the loop by asking the sender to change its pace. It does this with one-cycle request pulses, coded as SLOW or FAST, sent to a downstream command formatter.

A high level raises a SLOW request and a low level raises a FAST request. After a request the block stays in a requesting state. It returns to its normal state only once the level has come back past the midpoint of the two thresholds, which gives hysteresis. While the condition persists, the request is repeated at a paced interval set by a hold-off count, so the bus is not flooded with commands. A threshold pair that is not ordered is flagged as an error and silences every request. Empty and full indications are reported on their own outputs, apart from the rate requests.

Top module: `rate_buffer_monitor`

## Requirements
- R1: While `rst_n` is low, every output is 0 and `reqState` is NORMAL (code 0).
- R2: In NORMAL with a valid configuration and `level >= hiThresh`, the next edge gives `reqPulse`=1 for one cycle with `reqSlow`=1, and `reqState` becomes SLOW-REQUESTED (code 1).
- R3: In NORMAL with a valid configuration, `level < hiThresh` and `level <= loThresh`, the next edge gives `reqPulse`=1 with `reqSlow`=0, and `reqState` becomes FAST-REQUESTED (code 2).
- R4: While the triggering condition persists in a requesting state, the request is repeated with exactly `holdCycles`+1 cycles between pulses, and there is no pulse in between. With `holdCycles`=0 a pulse appears every cycle.
- R5: In SLOW-REQUESTED the state returns to NORMAL, with no pulse, on the edge after `level <= mid`, where mid = (hiThresh+loThresh)>>1. While the level stays above mid the state remains SLOW-REQUESTED.
- R6: In FAST-REQUESTED the state returns to NORMAL, with no pulse, on the edge after `level >= mid`. While the level stays below mid the state remains FAST-REQUESTED.
- R7: When `hiThresh <= loThresh`, on the next edge `cfgErr`=1, `reqState`=NORMAL and no pulse is issued, whatever the level. Once the configuration is valid again, `cfgErr` clears on the next edge.
- R8: `emptyFlag` is `level == 0` and `fullFlag` is `level >= FULL_LEVEL`. Each is registered one edge after the level, independent of the request state and of the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level | input | LEVEL_W | Current buffer fill level |
| hiThresh | input | LEVEL_W | Upper threshold (SLOW trigger) |
| loThresh | input | LEVEL_W | Lower threshold (FAST trigger) |
| holdCycles | input | HOLD_W | Hold-off count between repeated requests |
| reqPulse | output | 1 | One-cycle request strobe |
| reqSlow | output | 1 | Request code with the strobe: 1 = SLOW, 0 = FAST |
| reqState | output | 2 | 0 NORMAL, 1 SLOW-REQUESTED, 2 FAST-REQUESTED |
| cfgErr | output | 1 | Threshold pair not ordered |
| emptyFlag | output | 1 | Buffer empty |
| fullFlag | output | 1 | Buffer at or above full level |

## Verification
The bench lands the level exactly on each threshold and exactly on the midpoint. A design that used strict compares would miss a request or stay latched in a requesting state. It counts the spacing of repeated pulses, including a hold-off of zero, where an off-by-one counter would show spacing of holdCycles or holdCycles+2, or a stuck single pulse. It sets equal and inverted thresholds to catch a design that still issues requests or fails to raise and clear the error flag. It also drives the empty and full extremes to catch flags that are swapped or tied to the request state.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_SLOW   = 2'd1,
    ST_FAST   = 2'd2
  } rateState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHold;
    logic clearHold;
  } holdCtl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic atHigh;
    logic atLow;
    logic atOrBelowMid;
    logic atOrAboveMid;
    logic cfgBad;
    logic holdDone;
  } levelStat_t;

endpackage

// File: rtl/rcm_datapath.sv
module rcm_datapath
  import rcm_pkg::*;
#(
  parameter int LEVEL_W    = 7,
  parameter int HOLD_W     = 8,
  parameter int FULL_LEVEL = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] level,
  input  logic [LEVEL_W-1:0] hiThresh,
  input  logic [LEVEL_W-1:0] loThresh,
  input  logic [HOLD_W-1:0]  holdCycles,
  input  holdCtl_t           ctl,
  output levelStat_t         stat,
  output logic               emptyFlag,
  output logic               fullFlag
);

  localparam int SUM_W = LEVEL_W + 1;
  localparam logic [LEVEL_W-1:0] FULL_MARK = LEVEL_W'(FULL_LEVEL);

  logic [SUM_W-1:0]   threshSum;
  logic [LEVEL_W-1:0] midLevel;
  logic [HOLD_W-1:0]  holdCnt;

  // midpoint without overflow: keep the carry bit, then halve
  always_comb begin
    threshSum = {1'b0, hiThresh} + {1'b0, loThresh};
    midLevel  = threshSum[SUM_W-1:1];
  end

  always_comb begin
    stat.atHigh       = (level >= hiThresh);
    stat.atLow        = (level <= loThresh);
    stat.atOrBelowMid = (level <= midLevel);
    stat.atOrAboveMid = (level >= midLevel);
    stat.cfgBad       = (hiThresh <= loThresh);
    stat.holdDone     = (holdCnt == '0);
  end

  // hold-off counter paces repeated requests
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdCnt <= '0;
    end else if (ctl.loadHold) begin
      holdCnt <= holdCycles;
    end else if (ctl.clearHold) begin
      holdCnt <= '0;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // occupancy extremes, independent of the request logic
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emptyFlag <= 1'b0;
      fullFlag  <= 1'b0;
    end else begin
      emptyFlag <= (level == '0);
      fullFlag  <= (level >= FULL_MARK);
    end
  end

endmodule

// File: rtl/rcm_control.sv
module rcm_control
  import rcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  levelStat_t stat,
  output holdCtl_t   ctl,
  output logic       reqPulse,
  output logic       reqSlow,
  output logic [1:0] reqState,
  output logic       cfgErr
);

  rateState_e curState;
  rateState_e nxtState;
  logic       firePulse;
  logic       fireSlow;

  always_comb begin
    nxtState  = curState;
    firePulse = 1'b0;
    fireSlow  = 1'b0;
    ctl       = '0;
    if (stat.cfgBad) begin
      nxtState      = ST_NORMAL;
      ctl.clearHold = 1'b1;
    end else begin
      unique case (curState)
        ST_NORMAL: begin
          if (stat.atHigh) begin
            nxtState     = ST_SLOW;
            firePulse    = 1'b1;
            fireSlow     = 1'b1;
            ctl.loadHold = 1'b1;
          end else if (stat.atLow) begin
            nxtState     = ST_FAST;
            firePulse    = 1'b1;
            ctl.loadHold = 1'b1;
          end
        end
        ST_SLOW: begin
          if (stat.atOrBelowMid) begin
            nxtState = ST_NORMAL;
          end else if (stat.atHigh && stat.holdDone) begin
            firePulse    = 1'b1;
            fireSlow     = 1'b1;
            ctl.loadHold = 1'b1;
          end
        end
        ST_FAST: begin
          if (stat.atOrAboveMid) begin
            nxtState = ST_NORMAL;
          end else if (stat.atLow && stat.holdDone) begin
            firePulse    = 1'b1;
            ctl.loadHold = 1'b1;
          end
        end
        default: nxtState = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curState <= ST_NORMAL;
      reqPulse <= 1'b0;
      reqSlow  <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      curState <= nxtState;
      reqPulse <= firePulse;
      reqSlow  <= fireSlow;
      cfgErr   <= stat.cfgBad;
    end
  end

  assign reqState = curState;

endmodule

// File: rtl/rate_buffer_monitor.sv
module rate_buffer_monitor
  import rcm_pkg::*;
#(
  parameter int LEVEL_W    = 7,
  parameter int HOLD_W     = 8,
  parameter int FULL_LEVEL = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] level,
  input  logic [LEVEL_W-1:0] hiThresh,
  input  logic [LEVEL_W-1:0] loThresh,
  input  logic [HOLD_W-1:0]  holdCycles,
  output logic               reqPulse,
  output logic               reqSlow,
  output logic [1:0]         reqState,
  output logic               cfgErr,
  output logic               emptyFlag,
  output logic               fullFlag
);

  holdCtl_t   holdCtl;
  levelStat_t levelStat;

  rcm_datapath #(
    .LEVEL_W   (LEVEL_W),
    .HOLD_W    (HOLD_W),
    .FULL_LEVEL(FULL_LEVEL)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .hiThresh  (hiThresh),
    .loThresh  (loThresh),
    .holdCycles(holdCycles),
    .ctl       (holdCtl),
    .stat      (levelStat),
    .emptyFlag (emptyFlag),
    .fullFlag  (fullFlag)
  );

  rcm_control u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat    (levelStat),
    .ctl     (holdCtl),
    .reqPulse(reqPulse),
    .reqSlow (reqSlow),
    .reqState(reqState),
    .cfgErr  (cfgErr)
  );

endmodule

// File: rtl/rcm_checker.sv
module rcm_checker #(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqPulse,
  input logic              reqSlow,
  input logic [1:0]        reqState,
  input logic              cfgErr,
  input logic              emptyFlag,
  input logic              fullFlag,
  input logic [HOLD_W-1:0] holdCycles
);

  // R2: a SLOW strobe leaves the block in the slow-requested state
  p_slow_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqPulse && reqSlow) |-> (reqState == 2'd1));

  // R3: a FAST strobe leaves the block in the fast-requested state
  p_fast_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqPulse && !reqSlow) |-> (reqState == 2'd2));

  // R4: back-to-back strobes only with a zero hold-off
  p_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reqPulse |=> (!reqPulse || $past(holdCycles) == '0));

  // R5/R6: returning to normal is silent
  p_quiet_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqState == 2'd0 && $past(reqState) != 2'd0) |-> !reqPulse);

  // R7: a bad configuration silences requests and parks in normal
  p_cfg_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> (!reqPulse && reqState == 2'd0));

  // R8: empty and full never together
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(emptyFlag && fullFlag));

endmodule

bind rate_buffer_monitor rcm_checker #(.HOLD_W(HOLD_W)) u_rcm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqPulse  (reqPulse),
  .reqSlow   (reqSlow),
  .reqState  (reqState),
  .cfgErr    (cfgErr),
  .emptyFlag (emptyFlag),
  .fullFlag  (fullFlag),
  .holdCycles(holdCycles)
);

// File: tb/tb_rate_buffer_monitor.sv
`timescale 1ns/1ps
module tb_rate_buffer_monitor;

  localparam int LW = 7;
  localparam int HW = 8;
  localparam int NVEC = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] level = '0;
  logic [LW-1:0] hiThresh = 7'd48;
  logic [LW-1:0] loThresh = 7'd16;
  logic [HW-1:0] holdCycles = 8'd3;
  logic          reqPulse, reqSlow, cfgErr, emptyFlag, fullFlag;
  logic [1:0]    reqState;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rate_buffer_monitor dut (
    .clk(clk), .rst_n(rst_n), .level(level), .hiThresh(hiThresh),
    .loThresh(loThresh), .holdCycles(holdCycles), .reqPulse(reqPulse),
    .reqSlow(reqSlow), .reqState(reqState), .cfgErr(cfgErr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag)
  );

  // {level, hi, lo, hold, expPulse, expSlow, expState, expErr}
  // states: 0 NORMAL, 1 SLOW-REQUESTED, 2 FAST-REQUESTED; mid = 32 for 48/16
  localparam logic [33:0] VEC [NVEC] = '{
    {7'd30, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd0, 1'b0},
    {7'd48, 7'd48, 7'd16, 8'd3, 1'b1, 1'b1, 2'd1, 1'b0},
    {7'd50, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd1, 1'b0},
    {7'd50, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd1, 1'b0},
    {7'd50, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd1, 1'b0},
    {7'd50, 7'd48, 7'd16, 8'd3, 1'b1, 1'b1, 2'd1, 1'b0},
    {7'd40, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd1, 1'b0},
    {7'd33, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd1, 1'b0},
    {7'd32, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd0, 1'b0},
    {7'd47, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd0, 1'b0},
    {7'd16, 7'd48, 7'd16, 8'd3, 1'b1, 1'b0, 2'd2, 1'b0},
    {7'd10, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd2, 1'b0},
    {7'd31, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd2, 1'b0},
    {7'd32, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd0, 1'b0},
    {7'd16, 7'd48, 7'd16, 8'd3, 1'b1, 1'b0, 2'd2, 1'b0},
    {7'd40, 7'd48, 7'd16, 8'd3, 1'b0, 1'b0, 2'd0, 1'b0},
    {7'd64, 7'd16, 7'd16, 8'd3, 1'b0, 1'b0, 2'd0, 1'b1},
    {7'd0,  7'd10, 7'd20, 8'd3, 1'b0, 1'b0, 2'd0, 1'b1},
    {7'd5,  7'd48, 7'd16, 8'd3, 1'b1, 1'b0, 2'd2, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [LW-1:0] l, input logic [LW-1:0] h,
                      input logic [LW-1:0] lo, input logic [HW-1:0] hd);
    @(negedge clk);
    level = l; hiThresh = h; loThresh = lo; holdCycles = hd;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    level = 7'd30; hiThresh = 7'd48; loThresh = 7'd16; holdCycles = 8'd3;
    @(posedge clk); #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    level = 7'd0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reqPulse", reqPulse, 0);
    check("R1 reqSlow", reqSlow, 0);
    check("R1 reqState", reqState, 0);
    check("R1 cfgErr", cfgErr, 0);
    check("R1 emptyFlag", emptyFlag, 0);
    check("R1 fullFlag", fullFlag, 0);

    // R8: occupancy flags
    @(negedge clk); rst_n = 1'b1;
    step(7'd0, 7'd48, 7'd16, 8'd3);
    check("R8 empty at 0", emptyFlag, 1);
    check("R8 full at 0", fullFlag, 0);
    step(7'd64, 7'd48, 7'd16, 8'd3);
    check("R8 empty at 64", emptyFlag, 0);
    check("R8 full at 64", fullFlag, 1);
    step(7'd63, 7'd16, 7'd16, 8'd3);
    check("R8 full at 63 with bad cfg", fullFlag, 0);
    check("R8 empty at 63", emptyFlag, 0);

    // table: R2 R3 R5 R6 R7 and the paced repeat of R4
    doReset();
    for (int i = 0; i < NVEC; i++) begin
      logic [33:0] v;
      v = VEC[i];
      step(v[33:27], v[26:20], v[19:13], v[12:5]);
      check($sformatf("R2/R3/R4/R5/R6/R7 row %0d reqPulse", i), reqPulse, v[4]);
      check($sformatf("R2/R3 row %0d reqSlow", i), reqSlow, v[3]);
      check($sformatf("R5/R6 row %0d reqState", i), reqState, v[2:1]);
      check($sformatf("R7 row %0d cfgErr", i), cfgErr, v[0]);
    end

    // R4: zero hold-off repeats every cycle
    doReset();
    for (int i = 0; i < 4; i++) begin
      step(7'd60, 7'd48, 7'd16, 8'd0);
      check("R4 hold0 pulse", reqPulse, 1);
      check("R4 hold0 slow", reqSlow, 1);
    end

    // R4: persistent FAST with hold-off 2 repeats every 3 cycles
    doReset();
    for (int i = 0; i < 7; i++) begin
      step(7'd3, 7'd48, 7'd16, 8'd2);
      check($sformatf("R4 hold2 cycle %0d pulse", i), reqPulse, (i % 3 == 0) ? 1 : 0);
      check("R4 hold2 state", reqState, 2);
    end

    // R7: error clears once the configuration is valid again
    step(7'd30, 7'd20, 7'd20, 8'd2);
    check("R7 err set", cfgErr, 1);
    check("R7 no pulse", reqPulse, 0);
    step(7'd30, 7'd48, 7'd16, 8'd2);
    check("R7 err cleared", cfgErr, 0);
    check("R7 state normal", reqState, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule